// File: doc/BRIEF.md
# Video Test Pattern Pixel Generator

This block computes the colour of every active pixel of a display test pattern from externally supplied video timing. Each pixel clock it receives a data-enable, the two sync strobes, the current column and row numbers and the programmed active width and height, and one cycle later it presents a 24-bit RGB value together with delayed copies of the timing strobes. A control word chooses among solid colours, horizontal and vertical brightness ramps, a checkerboard, a four-colour banded checker and eight colour bars. It also sets inversion, 18-bit or 24-bit depth and a custom colour, and can turn on automatic scrolling through a chosen set of patterns.

Pixel data flows one way at the pixel rate. The output stream has a valid strobe (`out_valid`, the delayed data-enable) but no ready input. Video timing cannot be stalled, so the block accepts no back-pressure and a sink must take every valid pixel in the cycle it is presented. Ramp and bar positions come from accumulators that count pixels since data-enable rose and lines since vsync rose, so `col` and `row` are expected to count from zero in steps of one. The active width and height must be at least the number of ramp levels in use (256 in 24-bit mode, 64 in 18-bit mode) for ramps and bars to be exact.

Top module: `vtp_pixel_gen`

## Requirements
- R1: `out_valid`, `out_hsync` and `out_vsync` equal `de`, `hsync` and `vsync` one clock earlier. `out_rgb` is zero whenever `out_valid` is low, and all outputs are zero during reset. `out_rgb` packs red in bits 23:16, green in 15:8 and blue in 7:0.
- R2: The solid pattern codes give these colours: 1 white (FFFFFF), 2 black (000000), 3 red (FF0000), 4 green (00FF00), 5 blue (0000FF) and 14 `custom_rgb`.
- R3: Codes 6, 7, 8 and 9 are horizontal ramps with level v = floor(col × L / act_w). Code 6 puts v on all three channels, code 7 on red only, code 8 on green only and code 9 on blue only, and the other channels are zero.
- R4: Codes 10, 11, 12 and 13 are the same four ramps with v = floor(row × L / act_h), where row is the line index since vsync rose.
- R5: Code 0 is a checkerboard. With `chk_scale` low a square is 1×1 pixel, so the parity is col[0] xor row[0]; with it high a square is 8×8, so the parity is col[3] xor row[3]. Parity 0 shows white, or `custom_rgb` when `chk_custom` is high. Parity 1 shows black.
- R6: Code 15 is a banded checker with the same square size and parity as R5. Parity-1 squares are black. A parity-0 square takes the colour chosen by its square column index mod 4 from the order yellow, cyan, blue, red, or red, blue, cyan, yellow when `band_rev` is high.
- R7: When `bars_en` is high it overrides the pattern code. Bar index floor(col × 8 / act_w) from 0 to 7 selects white, yellow, cyan, green, magenta, red, blue, black.
- R8: When `invert` is high every one of the 24 colour bits is complemented. Inversion is applied before the depth masking of R9.
- R9: When `depth18` is high the ramp level count L is 64 and the level occupies channel bits 7:2. Bits 1:0 of every channel are forced to zero. When `depth18` is low, L is 256.
- R10: The pattern code in use changes only on a rising edge of `vsync`. With `scroll_en` low, `pat_sel` is captured on that edge, so a change in mid-frame has no effect until the next frame.
- R11: With `scroll_en` high, `pat_sel` is ignored. Every N-th rising edge of `vsync` (N = `scroll_frames`, and 0 counts as 1) the code moves to the next higher code whose bit in `scroll_mask` is set, wrapping from 15 to 0. With an all-zero mask the code holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| de | input | 1 | Input data-enable |
| hsync | input | 1 | Input horizontal sync |
| vsync | input | 1 | Input vertical sync, a frame starts on its rising edge |
| col | input | CW (12) | Column of the current pixel |
| row | input | CW (12) | Row of the current pixel |
| act_w | input | CW (12) | Active width in pixels |
| act_h | input | CW (12) | Active height in lines |
| pat_sel | input | 4 | Fixed pattern code |
| bars_en | input | 1 | Colour bars override |
| band_rev | input | 1 | Reverse band colour order of code 15 |
| chk_scale | input | 1 | 8×8 squares for codes 0 and 15 |
| chk_custom | input | 1 | Custom colour in place of white in the checkerboard |
| depth18 | input | 1 | 18-bit colour mode |
| invert | input | 1 | Complement output colour |
| scroll_en | input | 1 | Automatic scrolling enable |
| scroll_frames | input | FTW (8) | Frames per scroll step |
| scroll_mask | input | 16 | Codes visited by scrolling, bit n for code n |
| custom_rgb | input | 24 | Custom colour |
| out_valid | output | 1 | Delayed data-enable, qualifies `out_rgb` |
| out_hsync | output | 1 | Delayed horizontal sync |
| out_vsync | output | 1 | Delayed vertical sync |
| out_rgb | output | 24 | Pixel colour |

## Verification
The bench goes after the ramp ends. The last pixel of a 300-pixel line must read floor(299 × 256 / 300). If the accumulator compares with `>` where it should use `>=`, or starts a line from a stale remainder, every level comes out one step off. For vertical ramps, a vertical accumulator that does not clear on vsync carries its level into the next frame, so every line of the following frame is wrong.

In 18-bit mode the ramps and bars use the 64-level count. A design that kept 256 levels there would overflow the six-bit field and wrap. Inverted ramps and bars with the pattern code set to the banded checker show up mistakes in the order of override and inversion.

The pattern select is changed in the middle of a frame, which exposes a generator that samples it live where it should latch it at vsync. Scrolling runs over a sparse mask with wrap-around, a step length of zero and an empty mask, which catch an off-by-one frame count, a search that skips or repeats codes, and a generator that moves when no code is enabled.

// File: rtl/vtp_pkg.sv
package vtp_pkg;
  typedef logic [23:0] rgb_t;

  localparam rgb_t C_WHITE   = 24'hFFFFFF;
  localparam rgb_t C_BLACK   = 24'h000000;
  localparam rgb_t C_RED     = 24'hFF0000;
  localparam rgb_t C_GREEN   = 24'h00FF00;
  localparam rgb_t C_BLUE    = 24'h0000FF;
  localparam rgb_t C_YELLOW  = 24'hFFFF00;
  localparam rgb_t C_CYAN    = 24'h00FFFF;
  localparam rgb_t C_MAGENTA = 24'hFF00FF;

  localparam rgb_t DEPTH18_KEEP = 24'hFCFCFC;

  typedef enum logic [3:0] {
    PC_CHECKER = 4'd0,  PC_WHITE  = 4'd1,  PC_BLACK  = 4'd2,  PC_RED    = 4'd3,
    PC_GREEN   = 4'd4,  PC_BLUE   = 4'd5,  PC_HGRAY  = 4'd6,  PC_HRED   = 4'd7,
    PC_HGREEN  = 4'd8,  PC_HBLUE  = 4'd9,  PC_VGRAY  = 4'd10, PC_VRED   = 4'd11,
    PC_VGREEN  = 4'd12, PC_VBLUE  = 4'd13, PC_CUSTOM = 4'd14, PC_BANDED = 4'd15
  } pat_code_e;

  function automatic rgb_t bar_color(input logic [2:0] idx);
    case (idx)
      3'd0:    bar_color = C_WHITE;
      3'd1:    bar_color = C_YELLOW;
      3'd2:    bar_color = C_CYAN;
      3'd3:    bar_color = C_GREEN;
      3'd4:    bar_color = C_MAGENTA;
      3'd5:    bar_color = C_RED;
      3'd6:    bar_color = C_BLUE;
      default: bar_color = C_BLACK;
    endcase
  endfunction

  function automatic rgb_t band_color(input logic [1:0] idx);
    case (idx)
      2'd0:    band_color = C_YELLOW;
      2'd1:    band_color = C_CYAN;
      2'd2:    band_color = C_BLUE;
      default: band_color = C_RED;
    endcase
  endfunction
endpackage

// File: rtl/vtp_ramp_acc.sv
module vtp_ramp_acc #(
  parameter int CW = 12,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic [LW:0]   levels,
  input  logic [CW-1:0] size,
  output logic [LW-1:0] level
);
  localparam int AW = CW + 1;

  logic [AW-1:0] acc;
  logic [AW-1:0] sum;
  logic [AW-1:0] size_w;

  // Remainder of position*levels/size; level rises by one per carry.
  assign sum    = acc + AW'(levels);
  assign size_w = AW'(size);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= '0;
      level <= '0;
    end else if (clr) begin
      acc   <= '0;
      level <= '0;
    end else if (step) begin
      if (sum >= size_w) begin
        acc   <= sum - size_w;
        level <= level + 1'b1;
      end else begin
        acc   <= sum;
      end
    end
  end
endmodule

// File: rtl/vtp_scroll_seq.sv
module vtp_scroll_seq #(
  parameter int FTW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           frame_start,
  input  logic           scroll_en,
  input  logic [3:0]     sel,
  input  logic [FTW-1:0] frames,
  input  logic [15:0]    mask,
  output logic [3:0]     code
);
  logic [FTW-1:0] cnt;
  logic [FTW:0]   cnt_inc;
  logic [FTW:0]   limit;
  logic [3:0]     nxt;
  logic           found;

  assign cnt_inc = {1'b0, cnt} + 1'b1;
  assign limit   = (frames == '0) ? (FTW+1)'(1) : {1'b0, frames};

  // Next enabled code above the current one, wrapping; holds on empty mask.
  always_comb begin
    nxt   = code;
    found = 1'b0;
    for (int i = 1; i <= 16; i++) begin
      if (!found && mask[4'(code + 4'(i))]) begin
        nxt   = code + 4'(i);
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= 4'd0;
      cnt  <= '0;
    end else if (frame_start) begin
      if (!scroll_en) begin
        code <= sel;
        cnt  <= '0;
      end else if (cnt_inc >= limit) begin
        code <= nxt;
        cnt  <= '0;
      end else begin
        cnt  <= cnt_inc[FTW-1:0];
      end
    end
  end
endmodule

// File: rtl/vtp_color_sel.sv
module vtp_color_sel
  import vtp_pkg::*;
(
  input  logic [3:0] code,
  input  logic       bars_en,
  input  logic       band_rev,
  input  logic       chk_custom,
  input  rgb_t       custom_rgb,
  input  logic       parity,
  input  logic [1:0] band,
  input  logic [7:0] hval,
  input  logic [7:0] vval,
  input  logic [2:0] bar,
  output rgb_t       rgb
);
  logic [1:0] band_idx;
  assign band_idx = band_rev ? ~band : band;

  always_comb begin
    if (bars_en) begin
      rgb = bar_color(bar);
    end else begin
      case (pat_code_e'(code))
        PC_CHECKER: rgb = parity ? C_BLACK : (chk_custom ? custom_rgb : C_WHITE);
        PC_WHITE:   rgb = C_WHITE;
        PC_BLACK:   rgb = C_BLACK;
        PC_RED:     rgb = C_RED;
        PC_GREEN:   rgb = C_GREEN;
        PC_BLUE:    rgb = C_BLUE;
        PC_HGRAY:   rgb = {hval, hval, hval};
        PC_HRED:    rgb = {hval, 8'h00, 8'h00};
        PC_HGREEN:  rgb = {8'h00, hval, 8'h00};
        PC_HBLUE:   rgb = {8'h00, 8'h00, hval};
        PC_VGRAY:   rgb = {vval, vval, vval};
        PC_VRED:    rgb = {vval, 8'h00, 8'h00};
        PC_VGREEN:  rgb = {8'h00, vval, 8'h00};
        PC_VBLUE:   rgb = {8'h00, 8'h00, vval};
        PC_CUSTOM:  rgb = custom_rgb;
        default:    rgb = parity ? C_BLACK : band_color(band_idx);
      endcase
    end
  end
endmodule

// File: rtl/vtp_pixel_gen.sv
module vtp_pixel_gen
  import vtp_pkg::*;
#(
  parameter int CW  = 12,
  parameter int FTW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           de,
  input  logic           hsync,
  input  logic           vsync,
  input  logic [CW-1:0]  col,
  input  logic [CW-1:0]  row,
  input  logic [CW-1:0]  act_w,
  input  logic [CW-1:0]  act_h,
  input  logic [3:0]     pat_sel,
  input  logic           bars_en,
  input  logic           band_rev,
  input  logic           chk_scale,
  input  logic           chk_custom,
  input  logic           depth18,
  input  logic           invert,
  input  logic           scroll_en,
  input  logic [FTW-1:0] scroll_frames,
  input  logic [15:0]    scroll_mask,
  input  logic [23:0]    custom_rgb,
  output logic           out_valid,
  output logic           out_hsync,
  output logic           out_vsync,
  output logic [23:0]    out_rgb
);
  localparam int LW = 8;

  logic          de_prev, vs_prev;
  logic          vs_rise, de_fall;
  logic [LW:0]   levels;
  logic [LW-1:0] hlev, vlev;
  logic [7:0]    hval, vval;
  logic [2:0]    bar;
  logic          parity;
  logic [1:0]    band;
  logic [3:0]    cur_code;
  rgb_t          base_rgb, shaded_rgb;
  logic          unused_coord;

  assign vs_rise = vsync & ~vs_prev;
  assign de_fall = de_prev & ~de;
  assign levels  = depth18 ? (LW+1)'(64) : (LW+1)'(256);

  vtp_ramp_acc #(.CW(CW), .LW(LW)) u_hramp (
    .clk(clk), .rst_n(rst_n), .clr(~de), .step(de),
    .levels(levels), .size(act_w), .level(hlev)
  );

  vtp_ramp_acc #(.CW(CW), .LW(LW)) u_vramp (
    .clk(clk), .rst_n(rst_n), .clr(vs_rise), .step(de_fall),
    .levels(levels), .size(act_h), .level(vlev)
  );

  vtp_scroll_seq #(.FTW(FTW)) u_seq (
    .clk(clk), .rst_n(rst_n), .frame_start(vs_rise), .scroll_en(scroll_en),
    .sel(pat_sel), .frames(scroll_frames), .mask(scroll_mask), .code(cur_code)
  );

  // Level placement and bar index depend on the active depth.
  assign hval   = depth18 ? {hlev[5:0], 2'b00} : hlev;
  assign vval   = depth18 ? {vlev[5:0], 2'b00} : vlev;
  assign bar    = depth18 ? hlev[5:3] : hlev[7:5];
  assign parity = chk_scale ? (col[3] ^ row[3]) : (col[0] ^ row[0]);
  assign band   = chk_scale ? col[4:3] : col[1:0];
  assign unused_coord = ^{col[CW-1:5], col[2], row[CW-1:4], row[2:1]};

  vtp_color_sel u_color (
    .code(cur_code), .bars_en(bars_en), .band_rev(band_rev),
    .chk_custom(chk_custom), .custom_rgb(custom_rgb), .parity(parity),
    .band(band), .hval(hval), .vval(vval), .bar(bar), .rgb(base_rgb)
  );

  always_comb begin
    shaded_rgb = invert ? ~base_rgb : base_rgb;
    if (depth18) shaded_rgb = shaded_rgb & DEPTH18_KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      de_prev   <= 1'b0;
      vs_prev   <= 1'b0;
      out_valid <= 1'b0;
      out_hsync <= 1'b0;
      out_vsync <= 1'b0;
      out_rgb   <= '0;
    end else begin
      de_prev   <= de;
      vs_prev   <= vsync;
      out_valid <= de;
      out_hsync <= hsync;
      out_vsync <= vsync;
      out_rgb   <= de ? shaded_rgb : '0;
    end
  end
endmodule

// File: rtl/vtp_pixel_gen_chk.sv
module vtp_pixel_gen_chk #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          de,
  input logic [CW-1:0] col,
  input logic          invert,
  input logic          depth18,
  input logic          bars_en,
  input logic          out_valid,
  input logic [23:0]   out_rgb,
  input logic [3:0]    cur_code,
  input logic          vs_rise
);
  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    de |=> out_valid);

  // R1
  blank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !de |=> (!out_valid && out_rgb == 24'h0));

  // R9
  depth_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    depth18 |=> ((out_rgb & 24'h030303) == 24'h0));

  // R10
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_rise |=> $stable(cur_code));

  // R7
  first_bar_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (de && !$past(de) && bars_en && !invert && !depth18 && col == '0)
      |=> out_rgb == 24'hFFFFFF);

  // R8
  invert_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (de && invert && !depth18 && !bars_en && cur_code == 4'd2)
      |=> out_rgb == 24'hFFFFFF);
endmodule

bind vtp_pixel_gen vtp_pixel_gen_chk #(.CW(CW)) u_vtp_chk (
  .clk(clk), .rst_n(rst_n), .de(de), .col(col), .invert(invert),
  .depth18(depth18), .bars_en(bars_en), .out_valid(out_valid),
  .out_rgb(out_rgb), .cur_code(cur_code), .vs_rise(vs_rise)
);

// File: tb/vtp_pixel_gen_bench.sv
module vtp_pixel_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        de = 0, hsync = 0, vsync = 0;
  logic [11:0] col = 0, row = 0, act_w = 12'd16, act_h = 12'd2;
  logic [3:0]  pat_sel = 0;
  logic        bars_en = 0, band_rev = 0, chk_scale = 0, chk_custom = 0;
  logic        depth18 = 0, invert = 0, scroll_en = 0;
  logic [7:0]  scroll_frames = 0;
  logic [15:0] scroll_mask = 0;
  logic [23:0] custom_rgb = 24'h3A5C96;
  logic        out_valid, out_hsync, out_vsync;
  logic [23:0] out_rgb;

  int    n_checks = 0, n_fails = 0;
  string req_tag = "R1";
  bit    mid_en = 0;
  logic [3:0] mid_sel = 0;

  always #5 clk = ~clk;

  vtp_pixel_gen u_vtp_pixel_gen (
    .clk(clk), .rst_n(rst_n), .de(de), .hsync(hsync), .vsync(vsync),
    .col(col), .row(row), .act_w(act_w), .act_h(act_h), .pat_sel(pat_sel),
    .bars_en(bars_en), .band_rev(band_rev), .chk_scale(chk_scale),
    .chk_custom(chk_custom), .depth18(depth18), .invert(invert),
    .scroll_en(scroll_en), .scroll_frames(scroll_frames),
    .scroll_mask(scroll_mask), .custom_rgb(custom_rgb),
    .out_valid(out_valid), .out_hsync(out_hsync), .out_vsync(out_vsync),
    .out_rgb(out_rgb)
  );

  // Reference model state
  int m_code = 0, m_cnt = 0;
  bit m_vsp = 0;
  bit e_valid = 0, e_hs = 0, e_vs = 0;
  logic [23:0] e_rgb = 0;

  function automatic int mk(int r, int g, int b);
    return (r << 16) | (g << 8) | b;
  endfunction

  function automatic logic [23:0] ref_pixel(int code, int c, int r);
    int lv, hl, vl, sx, sy, px, bi;
    int bars[8];
    int bands[4];
    int v;
    bars  = '{mk(255,255,255), mk(255,255,0), mk(0,255,255), mk(0,255,0),
              mk(255,0,255), mk(255,0,0), mk(0,0,255), 0};
    bands = '{mk(255,255,0), mk(0,255,255), mk(0,0,255), mk(255,0,0)};
    lv = depth18 ? 64 : 256;
    hl = (c * lv) / int'(act_w);
    vl = (r * lv) / int'(act_h);
    if (depth18) begin hl = hl * 4; vl = vl * 4; end
    sx = chk_scale ? c / 8 : c;
    sy = chk_scale ? r / 8 : r;
    px = (sx + sy) % 2;
    if (bars_en) v = bars[(c * 8) / int'(act_w)];
    else case (code)
      0:  v = (px != 0) ? 0 : (chk_custom ? int'(custom_rgb) : mk(255,255,255));
      1:  v = mk(255,255,255);
      2:  v = 0;
      3:  v = mk(255,0,0);
      4:  v = mk(0,255,0);
      5:  v = mk(0,0,255);
      6:  v = mk(hl,hl,hl);
      7:  v = mk(hl,0,0);
      8:  v = mk(0,hl,0);
      9:  v = mk(0,0,hl);
      10: v = mk(vl,vl,vl);
      11: v = mk(vl,0,0);
      12: v = mk(0,vl,0);
      13: v = mk(0,0,vl);
      14: v = int'(custom_rgb);
      default: begin
        bi = sx % 4;
        if (band_rev) bi = 3 - bi;
        v = (px != 0) ? 0 : bands[bi];
      end
    endcase
    if (invert) v = v ^ 24'hFFFFFF;
    if (depth18) v = v & 24'hFCFCFC;
    return v[23:0];
  endfunction

  function automatic int next_enabled(int cur);
    for (int i = 1; i <= 16; i++)
      if (scroll_mask[(cur + i) % 16]) return (cur + i) % 16;
    return cur;
  endfunction

  always @(posedge clk) begin
    bit rise;
    int lim;
    if (!rst_n) begin
      e_valid = 0; e_hs = 0; e_vs = 0; e_rgb = 0;
      m_code = 0; m_cnt = 0; m_vsp = 0;
    end else begin
      e_valid = de; e_hs = hsync; e_vs = vsync;
      e_rgb = de ? ref_pixel(m_code, int'(col), int'(row)) : 24'h0;
      rise = vsync && !m_vsp;
      m_vsp = vsync;
      if (rise) begin
        if (!scroll_en) begin m_code = int'(pat_sel); m_cnt = 0; end
        else begin
          lim = (scroll_frames == 0) ? 1 : int'(scroll_frames);
          if (m_cnt + 1 >= lim) begin m_cnt = 0; m_code = next_enabled(m_code); end
          else m_cnt = m_cnt + 1;
        end
      end
    end
    #1;
    n_checks++;
    if (out_valid !== e_valid || out_hsync !== e_hs || out_vsync !== e_vs ||
        out_rgb !== e_rgb) begin
      n_fails++;
      if (n_fails <= 20)
        $display("FAIL %s t=%0t col=%0d row=%0d: got v%b h%b s%b rgb=%h, expected v%b h%b s%b rgb=%h",
                 req_tag, $time, col, row, out_valid, out_hsync, out_vsync, out_rgb,
                 e_valid, e_hs, e_vs, e_rgb);
    end
  end

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      de = 0; hsync = 0; vsync = 0;
    end
  endtask

  task automatic frame(int w, int h);
    @(negedge clk);
    act_w = 12'(w); act_h = 12'(h);
    repeat (3) begin @(negedge clk); vsync = 1; de = 0; end
    idle(2);
    for (int r = 0; r < h; r++) begin
      if (mid_en && r == 1) pat_sel = mid_sel;
      for (int c = 0; c < w; c++) begin
        @(negedge clk);
        de = 1; hsync = 0; col = 12'(c); row = 12'(r);
      end
      @(negedge clk); de = 0; hsync = 1;
      @(negedge clk); hsync = 1;
      idle(4);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: run did not complete, got timeout, expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    // R1: reset state compared every cycle while rst_n is low
    req_tag = "R1";
    repeat (4) @(negedge clk);
    rst_n = 1;
    idle(3);

    // R2: solid colours and custom colour
    req_tag = "R2";
    foreach (pat_sel[i]) ;
    for (int k = 0; k < 6; k++) begin
      pat_sel = (k == 5) ? 4'd14 : 4'(k + 1);
      frame(16, 2);
    end
    // R8: inversion of solids
    req_tag = "R8";
    invert = 1;
    pat_sel = 4'd3; frame(16, 2);
    pat_sel = 4'd2; frame(16, 2);
    pat_sel = 4'd14; frame(16, 2);
    invert = 0;

    // R3: horizontal ramps, 24-bit
    req_tag = "R3";
    for (int k = 6; k <= 9; k++) begin pat_sel = 4'(k); frame(300, 2); end
    pat_sel = 4'd6; frame(256, 2);
    req_tag = "R8"; invert = 1; pat_sel = 4'd7; frame(300, 2); invert = 0;
    // R9: 18-bit ramps and masking
    req_tag = "R9";
    depth18 = 1;
    pat_sel = 4'd6; frame(100, 2);
    pat_sel = 4'd14; frame(16, 2);
    invert = 1; pat_sel = 4'd9; frame(64, 2); invert = 0;
    depth18 = 0;

    // R4: vertical ramps
    req_tag = "R4";
    pat_sel = 4'd10; frame(4, 256);
    pat_sel = 4'd12; frame(4, 260);
    invert = 1; pat_sel = 4'd13; frame(3, 256); invert = 0;
    req_tag = "R9";
    depth18 = 1; pat_sel = 4'd11; frame(3, 70); depth18 = 0;

    // R5: checkerboard variants
    req_tag = "R5";
    pat_sel = 4'd0;
    chk_scale = 0; chk_custom = 0; frame(24, 20);
    chk_custom = 1; frame(24, 20);
    chk_scale = 1; frame(40, 20);
    chk_custom = 0; frame(40, 20);
    chk_scale = 0;

    // R6: banded checker, both orders and scales
    req_tag = "R6";
    pat_sel = 4'd15;
    band_rev = 0; frame(40, 4);
    band_rev = 1; frame(40, 4);
    chk_scale = 1; frame(64, 18);
    band_rev = 0; frame(64, 18);
    chk_scale = 0;

    // R7: colour bars override the code
    req_tag = "R7";
    bars_en = 1;
    pat_sel = 4'd15; frame(300, 2);
    frame(256, 2);
    depth18 = 1; frame(80, 2); depth18 = 0;
    invert = 1; frame(300, 2); invert = 0;
    bars_en = 0;

    // R10: pat_sel change mid-frame waits for next vsync
    req_tag = "R10";
    pat_sel = 4'd1; mid_en = 1; mid_sel = 4'd4;
    frame(16, 4);
    mid_en = 0;
    frame(16, 4);
    mid_en = 1; mid_sel = 4'd6;
    frame(16, 3);
    mid_en = 0;

    // R11: auto-scroll over sparse mask, select ignored
    req_tag = "R11";
    pat_sel = 4'd1; frame(8, 2);
    scroll_en = 1; pat_sel = 4'd5;
    scroll_mask = 16'b0100_0000_0000_1010;
    scroll_frames = 8'd2;
    for (int k = 0; k < 8; k++) frame(8, 2);
    scroll_frames = 8'd0;
    for (int k = 0; k < 4; k++) frame(8, 2);
    scroll_mask = 16'h0;
    for (int k = 0; k < 3; k++) frame(8, 2);
    scroll_en = 0; frame(8, 2);

    idle(4);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule